// File: doc/BRIEF.md
# Stream Block Merger

This block sits in a valid/ready streaming path and joins a fixed number of consecutive input blocks into one longer output packet. Each input block is framed by a start marker on its first word and an end marker on its last word. The merger keeps the start marker of the first block in a group and the end marker of the last block. Every marker between those two is removed, so downstream logic sees one packet per group.

A side-band header word travels with the stream. It is sampled on the start word of every input block, but only the header of the first block in a group survives. That header leaves the block together with the merged packet's start word, flagged by its own valid. The header moves through the same two register stages as the data, so the two stay aligned under any pattern of backpressure. The group size is a compile-time parameter. Input blocks must be at least two words long.

Top module: `blk_merge`

## Requirements
- R1: During and directly after reset, out_valid and out_hdr_valid are low, in_ready is high, and the block counter is at block 0 of a group.
- R2: With out_ready held high, a word accepted at the input appears on the output exactly two clock cycles later.
- R3: out_sop is high only on the first word of the first block of each group of BLOCKS input blocks.
- R4: out_eop is high only on the last word of block BLOCKS-1 of each group.
- R5: Data words leave in the order they were accepted and keep their values, with no word lost or duplicated.
- R6: out_hdr_valid is high exactly on the output word that carries out_sop, and on no other word.
- R7: While out_valid is high and out_ready is low, out_valid, out_data, out_sop, out_eop, out_hdr_valid and out_hdr hold their values into the next cycle.
- R8: When both internal stages hold a word and out_ready is low, in_ready is low in that same cycle, so at most two words are accepted during a sustained stall.
- R9: The block counter advances on each accepted input eop and returns to zero after BLOCKS eops, so every group starts a new output packet.
- R10: out_hdr equals the in_hdr value that was present on the accepted sop word of the group's first block; in_hdr on other words and on later blocks of the group has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | DATA_W | Input data word |
| in_sop | input | 1 | First word of an input block |
| in_eop | input | 1 | Last word of an input block |
| in_hdr | input | HDR_W | Side-band header, sampled at accepted input sop |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Sink takes the output word this cycle |
| out_data | output | DATA_W | Output data word |
| out_sop | output | 1 | First word of a merged packet |
| out_eop | output | 1 | Last word of a merged packet |
| out_hdr_valid | output | 1 | Header valid, aligned with out_sop |
| out_hdr | output | HDR_W | Header of the merged packet |

## Verification
The packet-framing checks assume every input block is well formed: it opens with sop, closes with eop and is at least two words long, with no sop before an open block has ended. The stimulus only builds blocks through one task that marks the first and last word of a block of length two or more. That task holds each word until the handshake completes and never drops in_valid in the middle of a word. Backpressure comes only from out_ready, which the bench changes just after a clock edge. The hold and stall properties therefore see stable inputs across each edge.

// File: rtl/blk_merge.sv
module blk_merge #(
  parameter int DATA_W = 16,
  parameter int HDR_W  = 32,
  parameter int BLOCKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [HDR_W-1:0]  in_hdr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_hdr_valid,
  output logic [HDR_W-1:0]  out_hdr
);

  localparam int CNT_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
  localparam logic [CNT_W-1:0] LAST_BLK = CNT_W'(BLOCKS - 1);

  logic [CNT_W-1:0]  blk_cnt;
  logic              first_blk, last_blk, take, advance;

  logic              s1_v, s1_sop, s1_eop, s1_hv;
  logic [DATA_W-1:0] s1_d;
  logic [HDR_W-1:0]  s1_h;

  logic              s2_v, s2_sop, s2_eop, s2_hv;
  logic [DATA_W-1:0] s2_d;
  logic [HDR_W-1:0]  s2_h;

  assign first_blk = (blk_cnt == '0);
  assign last_blk  = (blk_cnt == LAST_BLK);
  assign advance   = s1_v && (!s2_v || out_ready);
  assign in_ready  = !s1_v || advance;
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      blk_cnt <= '0;
    else if (take && in_eop)
      blk_cnt <= last_blk ? '0 : blk_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_d   <= '0;
      s1_sop <= 1'b0;
      s1_eop <= 1'b0;
      s1_hv  <= 1'b0;
      s1_h   <= '0;
    end else if (take) begin
      s1_v   <= 1'b1;
      s1_d   <= in_data;
      s1_sop <= in_sop && first_blk;
      s1_eop <= in_eop && last_blk;
      s1_hv  <= in_sop && first_blk;
      if (in_sop && first_blk)
        s1_h <= in_hdr;
    end else if (advance) begin
      s1_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_d   <= '0;
      s2_sop <= 1'b0;
      s2_eop <= 1'b0;
      s2_hv  <= 1'b0;
      s2_h   <= '0;
    end else if (advance) begin
      s2_v   <= 1'b1;
      s2_d   <= s1_d;
      s2_sop <= s1_sop;
      s2_eop <= s1_eop;
      s2_hv  <= s1_hv;
      s2_h   <= s1_h;
    end else if (out_ready) begin
      s2_v <= 1'b0;
    end
  end

  assign out_valid     = s2_v;
  assign out_data      = s2_d;
  assign out_sop       = s2_v && s2_sop;
  assign out_eop       = s2_v && s2_eop;
  assign out_hdr_valid = s2_v && s2_hv;
  assign out_hdr       = s2_h;

endmodule

// File: rtl/blk_merge_chk.sv
module blk_merge_chk #(
  parameter int DATA_W = 16,
  parameter int HDR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_hdr_valid,
  input logic [HDR_W-1:0]  out_hdr,
  input logic              s1_v,
  input logic              s2_v
);

  logic open_pkt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      open_pkt <= 1'b0;
    else if (out_valid && out_ready) begin
      if (out_eop)
        open_pkt <= 1'b0;
      else if (out_sop)
        open_pkt <= 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_hdr_valid && in_ready));

  a_r3_sop_starts_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !open_pkt);

  a_r4_eop_closes_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |-> (open_pkt || out_sop));

  a_r6_hdr_on_sop: assert property (@(posedge clk) disable iff (!rst_n)
    out_hdr_valid |-> (out_valid && out_sop));

  a_r6_sop_has_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> out_hdr_valid);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) &&
      $stable(out_eop) && $stable(out_hdr_valid) && $stable(out_hdr)));

  a_r8_full_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s2_v && !out_ready) |-> !in_ready);

endmodule

bind blk_merge blk_merge_chk #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_sop      (out_sop),
  .out_eop      (out_eop),
  .out_hdr_valid(out_hdr_valid),
  .out_hdr      (out_hdr),
  .s1_v         (s1_v),
  .s2_v         (s2_v)
);

// File: tb/blk_merge_bench.sv
module blk_merge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int HW = 32;
  localparam int NB = 3;

  typedef struct packed {
    logic [DW-1:0] d;
    logic          s;
    logic          e;
    logic          hv;
    logic [HW-1:0] h;
    int            cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [HW-1:0] in_hdr = '0;
  logic in_ready, out_valid, out_sop, out_eop, out_hdr_valid;
  logic [DW-1:0] out_data;
  logic [HW-1:0] out_hdr;

  int n_chk = 0, n_fail = 0, cyc = 0, acc_total = 0, mcnt = 0;
  int n_osop = 0, n_oeop = 0;
  bit lat_on = 0, prev_stall = 0, done = 0;
  logic [DW-1:0] sv_d;
  logic sv_s, sv_e, sv_hv;
  logic [HW-1:0] sv_h;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_merge #(.DATA_W(DW), .HDR_W(HW), .BLOCKS(NB)) u_blk_merge (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_hdr(in_hdr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .out_hdr_valid(out_hdr_valid), .out_hdr(out_hdr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t x;
    cyc++;
    if (rst_n) begin
      if (prev_stall) begin
        check("R7 valid held", {63'b0, out_valid}, 64'd1);
        check("R7 data held", {48'b0, out_data}, {48'b0, sv_d});
        check("R7 markers held", {61'b0, out_sop, out_eop, out_hdr_valid}, {61'b0, sv_s, sv_e, sv_hv});
        check("R7 header held", {32'b0, out_hdr}, {32'b0, sv_h});
      end
      prev_stall = out_valid && !out_ready;
      sv_d = out_data; sv_s = out_sop; sv_e = out_eop; sv_hv = out_hdr_valid; sv_h = out_hdr;
      if (in_valid && in_ready) begin
        acc_total++;
        x.d = in_data;
        x.s = in_sop && (mcnt == 0);
        x.e = in_eop && (mcnt == NB - 1);
        x.hv = x.s;
        x.h = in_hdr;
        x.cyc = cyc;
        if (in_eop) mcnt = (mcnt == NB - 1) ? 0 : mcnt + 1;
        q.push_back(x);
      end
      if (out_valid && out_ready) begin
        if (out_sop) n_osop++;
        if (out_eop) n_oeop++;
        if (q.size() == 0) check("R5 unexpected output word", 64'd1, 64'd0);
        else begin
          x = q.pop_front();
          check("R5 data", {48'b0, out_data}, {48'b0, x.d});
          check("R3 sop", {63'b0, out_sop}, {63'b0, x.s});
          check("R4 eop", {63'b0, out_eop}, {63'b0, x.e});
          check("R6 header valid", {63'b0, out_hdr_valid}, {63'b0, x.hv});
          if (x.hv) check("R10 header value", {32'b0, out_hdr}, {32'b0, x.h});
          if (lat_on) check("R2 latency", 64'(cyc - x.cyc), 64'd2);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) step();
  endtask

  task automatic drive(logic [DW-1:0] d, logic s, logic e, logic [HW-1:0] h);
    bit got;
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_hdr = h;
    got = 0;
    while (!got) begin
      @(negedge clk);
      got = in_ready;
      step();
    end
  endtask

  task automatic send_block(int base, int len, int hbase, bit gap);
    for (int i = 0; i < len; i++) begin
      drive(DW'(base + i), i == 0, i == len - 1, HW'(hbase + i));
      if (gap) idle(1);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    @(negedge clk);
    check("R1 out_valid in reset", {63'b0, out_valid}, 64'd0);
    check("R1 out_hdr_valid in reset", {63'b0, out_hdr_valid}, 64'd0);
    step();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {63'b0, out_valid}, 64'd0);
    check("R1 in_ready after reset", {63'b0, in_ready}, 64'd1);
    step();
  endtask

  task automatic t_basic();
    int s0 = n_osop, e0 = n_oeop;
    lat_on = 1; out_ready = 1'b1;
    send_block(16'h100, 4, 32'hA000_0000, 0);
    send_block(16'h110, 2, 32'hA100_0000, 0);
    send_block(16'h120, 5, 32'hA200_0000, 0);
    send_block(16'h200, 3, 32'hB000_0000, 0);
    send_block(16'h210, 2, 32'hB100_0000, 0);
    send_block(16'h220, 2, 32'hB200_0000, 0);
    idle(5);
    check("R5 all words out (basic)", 64'(q.size()), 64'd0);
    check("R9 two packets started", 64'(n_osop - s0), 64'd2);
    check("R9 two packets ended", 64'(n_oeop - e0), 64'd2);
    lat_on = 0;
  endtask

  task automatic t_gaps();
    lat_on = 1; out_ready = 1'b1;
    send_block(16'h300, 2, 32'hC000_0000, 1);
    send_block(16'h310, 3, 32'hC100_0000, 1);
    send_block(16'h320, 2, 32'hC200_0000, 1);
    idle(5);
    check("R5 all words out (gaps)", 64'(q.size()), 64'd0);
    lat_on = 0;
  endtask

  task automatic t_stall();
    int a0;
    out_ready = 1'b0;
    a0 = acc_total;
    fork
      begin
        send_block(16'h400, 3, 32'hD000_0000, 0);
        send_block(16'h410, 3, 32'hD100_0000, 0);
        send_block(16'h420, 3, 32'hD200_0000, 0);
      end
      begin
        repeat (8) @(negedge clk);
        check("R8 accepted words during stall", 64'(acc_total - a0), 64'd2);
        check("R8 in_ready low while full", {63'b0, in_ready}, 64'd0);
        check("R7 output held during stall", {63'b0, out_valid}, 64'd1);
        step();
        out_ready = 1'b1;
      end
    join
    idle(5);
    check("R5 all words out (stall)", 64'(q.size()), 64'd0);
  endtask

  task automatic t_toggle();
    int s0 = n_osop, e0 = n_oeop;
    fork
      begin
        for (int k = 0; k < 60; k++) begin
          out_ready = (k % 3) != 0;
          step();
        end
        out_ready = 1'b1;
      end
      begin
        send_block(16'h500, 2, 32'hE000_0000, 0);
        send_block(16'h510, 4, 32'hE100_0000, 0);
        send_block(16'h520, 3, 32'hE200_0000, 0);
        send_block(16'h600, 5, 32'hF000_0000, 1);
        send_block(16'h610, 2, 32'hF100_0000, 0);
        send_block(16'h620, 2, 32'hF200_0000, 1);
      end
    join
    idle(6);
    check("R5 all words out (toggle)", 64'(q.size()), 64'd0);
    check("R9 sop count under toggling ready", 64'(n_osop - s0), 64'd2);
    check("R4 eop count under toggling ready", 64'(n_oeop - e0), 64'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_gaps();
    t_stall();
    t_toggle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule